// File: doc/BRIEF.md
# SIMD Unsigned Widening Extract Unit

This block performs the zero-shift form of an unsigned shift-left-long vector operation. It takes a 128-bit source vector and the 32-bit instruction word. It picks one 64-bit half of the source and zero-extends every element of that half to twice its width, which fills a 128-bit result. The element size and the half come from the instruction word. Element size comes from the four-bit size-and-shift field at bits [22:19], called `sz`. Half selection comes from bit 30, called `hi`.

The result is registered and appears exactly one cycle after the valid strobe, whatever the operand values. The destination register index is taken from bits [4:0] of the instruction and passed along with the result. Encodings that are not a zero-shift widening are not executed. For these the unit raises a flag and drives an all-zero result.

Top module: `uwiden_xtract`

## Requirements
- R1: `out_valid` is high in the cycle after each cycle with `in_valid` high, and low after each cycle with `in_valid` low; the latency is always one cycle.
- R2: With `sz` = 4'b0001 and bits [18:16] = 0, each of 8 source bytes becomes a 16-bit lane whose upper 8 bits are zero.
- R3: With `sz` = 4'b0010 and bits [18:16] = 0, each of 4 source halfwords becomes a 32-bit lane whose upper 16 bits are zero.
- R4: With `sz` = 4'b0100 and bits [18:16] = 0, each of 2 source words becomes a 64-bit lane whose upper 32 bits are zero.
- R5: With `hi` (bit 30) = 0 the elements come from source bits [63:0]; with `hi` = 1 they come from bits [127:64].
- R6: Result lane i holds element i of the selected half, and lane 0 sits in the least significant bits.
- R7: `out_reserved` is 1 and `out_data` is all zeros when `sz` is not exactly one of 0001, 0010 or 0100. This covers `sz`[3] = 1, `sz` = 0000, and more than one bit set. It also applies when bits [18:16] are nonzero, because then the shift is nonzero.
- R8: `out_rd` equals bits [4:0] of the instruction that was presented with the strobe.
- R9: While reset is active, `out_valid`, `out_reserved`, `out_data` and `out_rd` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction and source are valid this cycle |
| insn | input | 32 | Instruction word |
| src | input | 128 | Source vector |
| out_valid | output | 1 | Result valid |
| out_data | output | 128 | Widened result vector |
| out_rd | output | 5 | Destination register index |
| out_reserved | output | 1 | Encoding is not a zero-shift widening |

## Verification
The assertions assume that `in_valid` is held low while reset is active. They also assume that the instruction word is stable for the full cycle in which it is strobed, because several properties compare the registered outputs with the previous cycle's `insn`. The bench drives every input on the falling edge and keeps `in_valid` at zero through reset. Its stimulus mixes legal encodings for both halves with reserved `sz` patterns and nonzero shift bits, including back-to-back strobes and idle gaps.

// File: rtl/uwiden_xtract.sv
module uwiden_xtract #(
  parameter int VW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [31:0]   insn,
  input  logic [VW-1:0] src,
  output logic          out_valid,
  output logic [VW-1:0] out_data,
  output logic [4:0]    out_rd,
  output logic          out_reserved
);
  localparam int HW = VW / 2;

  logic [3:0]    sz;
  logic [2:0]    shamt;
  logic          hi;
  logic [HW-1:0] half;
  logic [VW-1:0] w16, w32, w64, res;
  logic          rsv;

  assign sz    = insn[22:19];
  assign shamt = insn[18:16];
  assign hi    = insn[30];
  assign half  = hi ? src[VW-1:HW] : src[HW-1:0];

  for (genvar i = 0; i < HW/8; i++) begin : g_b
    assign w16[16*i +: 16] = {8'b0, half[8*i +: 8]};
  end
  for (genvar i = 0; i < HW/16; i++) begin : g_h
    assign w32[32*i +: 32] = {16'b0, half[16*i +: 16]};
  end
  for (genvar i = 0; i < HW/32; i++) begin : g_w
    assign w64[64*i +: 64] = {32'b0, half[32*i +: 32]};
  end

  always_comb begin
    rsv = 1'b0;
    res = '0;
    if (shamt != 3'b000) rsv = 1'b1;
    else begin
      case (sz)
        4'b0001: res = w16;
        4'b0010: res = w32;
        4'b0100: res = w64;
        default: rsv = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_data     <= '0;
      out_rd       <= '0;
      out_reserved <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data     <= rsv ? '0 : res;
        out_rd       <= insn[4:0];
        out_reserved <= rsv;
      end
    end
  end
endmodule

module uwiden_xtract_chk #(
  parameter int VW = 128
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [31:0]   insn,
  input logic [VW-1:0] src,
  input logic          out_valid,
  input logic [VW-1:0] out_data,
  input logic [4:0]    out_rd,
  input logic          out_reserved
);
  a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> out_valid == $past(in_valid));

  a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_reserved) |-> out_data == '0);

  a_r7_top_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && insn[22]) |=> out_reserved);

  a_r8_rd: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_rd == $past(insn[4:0]));

  a_r2_byte_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && insn[22:16] == 7'b0001000) |=>
      (!out_reserved && (out_data & {(VW/16){16'hFF00}}) == '0));

  a_r4_word_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && insn[22:16] == 7'b0100000) |=>
      (!out_reserved && (out_data & {(VW/64){64'hFFFFFFFF_00000000}}) == '0));
endmodule

bind uwiden_xtract uwiden_xtract_chk #(.VW(VW)) i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn), .src(src),
  .out_valid(out_valid), .out_data(out_data), .out_rd(out_rd),
  .out_reserved(out_reserved)
);

// File: tb/test_uwiden_xtract.sv
module test_uwiden_xtract;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [31:0]  insn = '0;
  logic [127:0] src = '0;
  logic         out_valid;
  logic [127:0] out_data;
  logic [4:0]   out_rd;
  logic         out_reserved;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct packed {
    logic [127:0] data;
    logic [4:0]   rd;
    logic         rsv;
    logic [7:0]   tag;
  } exp_t;
  exp_t sb[$];

  uwiden_xtract i_uwiden_xtract (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn), .src(src),
    .out_valid(out_valid), .out_data(out_data), .out_rd(out_rd),
    .out_reserved(out_reserved)
  );

  always #5 clk = ~clk;

  function automatic logic [31:0] mk(bit q, logic [3:0] sz, logic [2:0] sh,
                                     logic [4:0] rn, logic [4:0] rd);
    return {1'b0, q, 1'b1, 6'b011110, sz, sh, 6'b101001, rn, rd};
  endfunction

  function automatic exp_t model(logic [31:0] w, logic [127:0] s, logic [7:0] tag);
    exp_t e;
    int esz;
    int base;
    e.data = '0; e.rd = w[4:0]; e.tag = tag; e.rsv = 1'b0;
    esz = 0;
    if (w[18:16] == 3'd0) begin
      if (w[22:19] == 4'b0001) esz = 8;
      else if (w[22:19] == 4'b0010) esz = 16;
      else if (w[22:19] == 4'b0100) esz = 32;
    end
    if (esz == 0) e.rsv = 1'b1;
    else begin
      base = w[30] ? 64 : 0;
      for (int l = 0; l < 64 / esz; l++)
        for (int b = 0; b < esz; b++)
          e.data[2*esz*l + b] = s[base + esz*l + b];
    end
    return e;
  endfunction

  task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic [31:0] w, logic [127:0] s, logic [7:0] tag);
    @(negedge clk);
    in_valid = 1'b1; insn = w; src = s;
    sb.push_back(model(w, s, tag));
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; insn = $urandom; src = {4{$urandom}};
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      exp_t e;
      if (sb.size() == 0) chk(0, "R1 unexpected valid", 1, 0);
      else begin
        e = sb.pop_front();
        case (e.tag)
          2: chk(out_data == e.data, "R2 byte widen", out_data, e.data);
          3: chk(out_data == e.data, "R3 half widen", out_data, e.data);
          4: chk(out_data == e.data, "R4 word widen", out_data, e.data);
          5: chk(out_data == e.data, "R5 half select", out_data, e.data);
          6: chk(out_data == e.data, "R6 lane order", out_data, e.data);
          default: chk(out_data == e.data, "R7 reserved data", out_data, e.data);
        endcase
        chk(out_reserved == e.rsv, "R7 reserved flag", out_reserved, e.rsv);
        chk(out_rd == e.rd, "R8 rd", out_rd, e.rd);
      end
    end
  end

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [127:0] r;
    repeat (3) @(negedge clk);
    chk(out_valid == 0 && out_data == '0 && out_rd == 0 && out_reserved == 0,
        "R9 reset state", {out_valid, out_reserved, out_rd}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 0, "R1 idle after reset", out_valid, 0);

    r = 128'hFFEEDDCCBBAA9988_7766554433221100;
    drive(mk(0, 4'b0001, 0, 5'd3, 5'd7), r, 2);
    drive(mk(1, 4'b0001, 0, 5'd3, 5'd8), r, 5);
    drive(mk(0, 4'b0010, 0, 5'd1, 5'd9), r, 3);
    drive(mk(1, 4'b0010, 0, 5'd1, 5'd10), r, 5);
    drive(mk(0, 4'b0100, 0, 5'd2, 5'd11), r, 4);
    drive(mk(1, 4'b0100, 0, 5'd2, 5'd31), r, 5);
    idle();
    @(negedge clk);
    chk(out_valid == 0, "R1 no valid after idle", out_valid, 0);
    drive(mk(0, 4'b0001, 0, 0, 0), {128{1'b1}}, 2);
    drive(mk(1, 4'b0010, 0, 0, 1), {128{1'b1}}, 3);
    drive(mk(0, 4'b0100, 0, 0, 2), {128{1'b1}}, 4);
    drive(mk(0, 4'b0001, 0, 0, 3), 128'h0F0E0D0C0B0A0908_0706050403020100, 6);
    drive(mk(1, 4'b1000, 0, 0, 4), {128{1'b1}}, 7);
    drive(mk(0, 4'b1111, 0, 0, 5), {128{1'b1}}, 7);
    drive(mk(0, 4'b0000, 0, 0, 6), {128{1'b1}}, 7);
    drive(mk(0, 4'b0011, 0, 0, 7), {128{1'b1}}, 7);
    drive(mk(0, 4'b0110, 0, 0, 8), {128{1'b1}}, 7);
    drive(mk(0, 4'b0001, 3'd1, 0, 9), {128{1'b1}}, 7);
    drive(mk(1, 4'b0100, 3'd4, 0, 10), {128{1'b1}}, 7);
    for (int k = 0; k < 200; k++) begin
      logic [3:0] s;
      logic [7:0] tg;
      s = 4'b0001 << (k % 3);
      tg = (k % 3 == 0) ? 8'd2 : (k % 3 == 1) ? 8'd3 : 8'd4;
      drive(mk(k[3], s, 0, $urandom, $urandom),
            {$urandom, $urandom, $urandom, $urandom}, tg);
      if (k % 7 == 0) idle();
    end
    idle();
    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R1 all results seen", sb.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule